// File: doc/BRIEF.md
# Threshold-Driven Block Transfer FIFO

This block buffers data between a host data port (driven by a CPU or a DMA engine) and a byte-wide card data stream. Storage is a 32-entry FIFO of 16-bit halfwords. Each halfword carries two card bytes, low byte first. A pair of counters tracks the bytes left in the current block and the blocks left in the transfer. The byte counter can run out in the middle of a halfword, and then that halfword carries a single byte.

A transfer starts with a pulse on `xfer_start`. `xfer_dir` chooses the direction. In the read direction, card bytes are packed into the FIFO and the host pops halfwords. In the write direction, the host pushes halfwords and the block unpacks them onto the card stream. Two programmable fill levels are compared with the fill count. Crossing the almost-full level (read) or the almost-empty level (write) raises a DMA request when DMA is enabled for that direction. Otherwise the crossing sets a status bit. The end of the transfer sets a done bit. A masked OR of the status bits drives one interrupt line.

The host reaches the block through a 3-bit register address: 0 data, 1 block length, 2 block count, 3 buffer configuration, 4 status, 5 interrupt mask. Any other address reads as zero.

Top module: `xfer_block_fifo`

## Requirements
- R1: The FIFO holds 32 halfwords in order. A host write to address 0 while 32 entries are held is dropped. A host read of address 0 on an empty FIFO returns the current head entry and does not move the head.
- R2: In the read direction, the first card byte of an entry lands in bits 7:0 and the second in bits 15:8. When a block ends after the first byte of an entry, that entry is pushed with bits 15:8 equal to zero.
- R3: In the write direction, bits 7:0 of the head entry go to the card before bits 15:8. When a block ends after the low byte, the entry is popped and its high byte is never sent.
- R4: Writing field 10:0 of address 1 sets the block length to that value plus one. Writing field 10:0 of address 2 sets the block count to that value plus one and reloads both the byte and block counters. Reads of addresses 1 and 2 return the bytes and blocks remaining. After length × count bytes the transfer ends, both counters reload, and status bit 3 is set on the same clock edge.
- R5: `card_rx_ready` is high only during an active read transfer while the fill count is at or below the almost-full level.
- R6: In the read direction, a fill count above the almost-full level drives `dma_rx_req` high in the same cycle when receive DMA is enabled. Otherwise it sets status bit 10 one edge later. When the count is not above the level, both are low.
- R7: In the write direction, a fill count below the almost-empty level drives `dma_tx_req` high in the same cycle when transmit DMA is enabled. Otherwise it sets status bit 11 one edge later. When the count is not below the level, both are low.
- R8: With no transfer active and the FIFO empty, both DMA requests and status bits 10 and 11 are low.
- R9: Address 3 holds the receive-DMA enable in bit 15, the almost-full level in bits 12:8, the transmit-DMA enable in bit 7 and the almost-empty level in bits 4:0. It resets to 0x1F00.
- R10: `irq` is the OR of the status bits ANDed with the 15-bit mask at address 5. Writing a one to status bit 3 clears it. Bits 10 and 11 follow their level conditions.
- R11: `xfer_start` empties the FIFO and clears any half-built entry. At most one card byte moves per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops on address 0) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from the address |
| xfer_start | input | 1 | Start a transfer |
| xfer_dir | input | 1 | 1 = card to host, 0 = host to card |
| card_rx_valid | input | 1 | Card byte offered |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Block accepts the card byte |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| irq | output | 1 | Masked status interrupt |

## Verification
Register writes, FIFO pushes and pops, and card byte handshakes all take effect at the rising edge where the strobe or handshake is seen. Read data, the DMA requests, `card_rx_ready`, `card_tx_valid` and `irq` follow that edge combinationally. The level bits 10 and 11 need one more edge. The bench drives at the falling edge and samples outputs at a falling edge at least one edge after the stimulus. Before it reads the level status bits, it waits two edges.

// File: rtl/xfer_fifo_pkg.sv
// Shared constants for the block transfer FIFO: register addresses,
// status bit positions and the fixed field layout of the buffer register.
package xfer_fifo_pkg;

    localparam int BYTE_W = 8;
    localparam int LVL_W  = 5;

    typedef enum logic [2:0] {
        ADDR_DATA   = 3'd0,
        ADDR_BLKLEN = 3'd1,
        ADDR_BLKCNT = 3'd2,
        ADDR_BUFCFG = 3'd3,
        ADDR_STATUS = 3'd4,
        ADDR_MASK   = 3'd5
    } reg_addr_e;

    localparam int ST_DONE_BIT = 3;
    localparam int ST_AF_BIT   = 10;
    localparam int ST_AE_BIT   = 11;

    localparam int CFG_RXEN_BIT = 15;
    localparam int CFG_AF_LSB   = 8;
    localparam int CFG_TXEN_BIT = 7;
    localparam int CFG_AE_LSB   = 0;

    typedef struct packed {
        logic             rx_en;
        logic [LVL_W-1:0] af_lvl;
        logic             tx_en;
        logic [LVL_W-1:0] ae_lvl;
    } buf_cfg_t;

endpackage

// File: rtl/xfer_fifo_mem.sv
// Circular halfword FIFO with fill count.
// Assumes DEPTH is a power of two. A push when full and a pop when empty are
// both dropped. Flush empties the FIFO and leaves the entry contents alone.
module xfer_fifo_mem #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH):0]     fill,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [WIDTH-1:0] entry [DEPTH];
    logic             do_push;
    logic             do_pop;

    assign full    = (fill == CNT_W'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = entry[rd_ptr];

    // One storage register per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (do_push && (wr_ptr == PTR_W'(g))) begin
                entry[g] <= push_data;
            end
        end
    end

    // Pointer and fill count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/xfer_blk_counter.sv
// Byte-per-block and block-per-transfer down counters.
// Both fields are stored as the written value plus one. Loading the block
// count reloads both counters. A step on the last byte of a block reloads
// the byte counter. A step on the last byte of the transfer also reloads
// the block counter.
module xfer_blk_counter #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_load,
    input  logic             cnt_load,
    input  logic [LEN_W-1:0] field,
    input  logic             step,
    output logic             byte_last,
    output logic             xfer_last,
    output logic [LEN_W:0]   bytes_left,
    output logic [LEN_W:0]   blocks_left
);
    localparam int CW = LEN_W + 1;

    logic [CW-1:0] blk_len;
    logic [CW-1:0] blk_num;
    logic [CW-1:0] field_p1;

    assign field_p1  = {1'b0, field} + CW'(1);
    assign byte_last = (bytes_left == CW'(1));
    assign xfer_last = byte_last && (blocks_left == CW'(1));

    // Programmed length and count; register writes win over steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_len     <= CW'(1);
            blk_num     <= CW'(1);
            bytes_left  <= CW'(1);
            blocks_left <= CW'(1);
        end else if (len_load) begin
            blk_len    <= field_p1;
            bytes_left <= field_p1;
        end else if (cnt_load) begin
            blk_num     <= field_p1;
            blocks_left <= field_p1;
            bytes_left  <= blk_len;
        end else if (step) begin
            if (byte_last) begin
                bytes_left  <= blk_len;
                blocks_left <= (blocks_left == CW'(1)) ? blk_num : blocks_left - 1'b1;
            end else begin
                bytes_left <= bytes_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/xfer_level_mon.sv
// Fill-level comparator. In the read direction a count above the
// almost-full level is a crossing; in the write direction a count below
// the almost-empty level is one. A crossing goes to the DMA request when
// DMA is enabled for that direction and to a level flag otherwise.
// No crossing is reported while idle with an empty FIFO.
module xfer_level_mon #(
    parameter int CNT_W = 6
) (
    input  xfer_fifo_pkg::buf_cfg_t cfg,
    input  logic [CNT_W-1:0]        fill,
    input  logic                    active,
    input  logic                    dir_rd,
    output logic                    rx_req,
    output logic                    tx_req,
    output logic                    af_flag,
    output logic                    ae_flag
);
    logic quiet;
    logic over;
    logic under;

    // Crossing decode and routing to request or flag.
    always_comb begin
        quiet   = !active && (fill == '0);
        over    = dir_rd && !quiet && (fill > CNT_W'(cfg.af_lvl));
        under   = !dir_rd && !quiet && (fill < CNT_W'(cfg.ae_lvl));
        rx_req  = over && cfg.rx_en;
        af_flag = over && !cfg.rx_en;
        tx_req  = under && cfg.tx_en;
        ae_flag = under && !cfg.tx_en;
    end

endmodule

// File: rtl/xfer_block_fifo.sv
// Block transfer FIFO top. Decodes host register accesses, packs card bytes
// into halfwords (read) or unpacks them (write), drives the block counters
// and reports level crossings, completion and the masked interrupt.
// Assumes the host does not write data during an active read transfer and
// does not read data during an active write transfer: those accesses are ignored.
module xfer_block_fifo #(
    parameter int DEPTH  = 32,
    parameter int LEN_W  = 11,
    parameter int MASK_W = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        xfer_start,
    input  logic        xfer_dir,
    input  logic        card_rx_valid,
    input  logic [7:0]  card_rx_data,
    output logic        card_rx_ready,
    output logic        card_tx_valid,
    output logic [7:0]  card_tx_data,
    input  logic        card_tx_ready,
    output logic        dma_rx_req,
    output logic        dma_tx_req,
    output logic        irq
);
    import xfer_fifo_pkg::*;

    localparam int ENTRY_W = 2 * BYTE_W;
    localparam int CNT_W   = $clog2(DEPTH) + 1;

    buf_cfg_t            cfg;
    logic [MASK_W-1:0]   int_mask;
    logic                active;
    logic                dir_rd;
    logic                have_lo;
    logic [BYTE_W-1:0]   lo_byte;
    logic                tx_half;
    logic                st_done;
    logic                st_af;
    logic                st_ae;
    logic [15:0]         status_vec;

    logic                in_rd;
    logic                in_wr;
    logic                rx_fire;
    logic                tx_fire;
    logic                byte_step;
    logic                wr_data;
    logic                rd_data;
    logic                push_en;
    logic                pop_en;
    logic [ENTRY_W-1:0]  push_word;
    logic [ENTRY_W-1:0]  head;
    logic [CNT_W-1:0]    fill_cnt;
    logic                fifo_full;
    logic                fifo_empty;
    logic                byte_last;
    logic                xfer_last;
    logic [LEN_W:0]      bytes_left;
    logic [LEN_W:0]      blocks_left;
    logic                af_flag;
    logic                ae_flag;

    // Transfer phase and host strobe decode.
    always_comb begin
        in_rd     = active && dir_rd;
        in_wr     = active && !dir_rd;
        wr_data   = host_wr && (host_addr == ADDR_DATA);
        rd_data   = host_rd && (host_addr == ADDR_DATA);
        card_rx_ready = in_rd && (fill_cnt <= CNT_W'(cfg.af_lvl));
        card_tx_valid = in_wr && !fifo_empty;
        card_tx_data  = tx_half ? head[ENTRY_W-1:BYTE_W] : head[BYTE_W-1:0];
        rx_fire   = card_rx_valid && card_rx_ready;
        tx_fire   = card_tx_valid && card_tx_ready;
        byte_step = rx_fire || tx_fire;
    end

    // FIFO push/pop source selection: card side while a transfer owns that end.
    always_comb begin
        if (in_rd) begin
            push_en   = rx_fire && (have_lo || byte_last);
            push_word = have_lo ? {card_rx_data, lo_byte} : {{BYTE_W{1'b0}}, card_rx_data};
        end else begin
            push_en   = wr_data;
            push_word = host_wdata;
        end
        pop_en = in_wr ? (tx_fire && (tx_half || byte_last)) : rd_data;
    end

    xfer_fifo_mem #(
        .DEPTH (DEPTH),
        .WIDTH (ENTRY_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (xfer_start),
        .push      (push_en),
        .push_data (push_word),
        .pop       (pop_en),
        .head      (head),
        .fill      (fill_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    xfer_blk_counter #(
        .LEN_W (LEN_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_load    (host_wr && (host_addr == ADDR_BLKLEN)),
        .cnt_load    (host_wr && (host_addr == ADDR_BLKCNT)),
        .field       (host_wdata[LEN_W-1:0]),
        .step        (byte_step),
        .byte_last   (byte_last),
        .xfer_last   (xfer_last),
        .bytes_left  (bytes_left),
        .blocks_left (blocks_left)
    );

    xfer_level_mon #(
        .CNT_W (CNT_W)
    ) u_lvl (
        .cfg     (cfg),
        .fill    (fill_cnt),
        .active  (active),
        .dir_rd  (dir_rd),
        .rx_req  (dma_rx_req),
        .tx_req  (dma_tx_req),
        .af_flag (af_flag),
        .ae_flag (ae_flag)
    );

    // Transfer activity, direction and byte packing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            dir_rd  <= 1'b0;
            have_lo <= 1'b0;
            lo_byte <= '0;
            tx_half <= 1'b0;
        end else if (xfer_start) begin
            active  <= 1'b1;
            dir_rd  <= xfer_dir;
            have_lo <= 1'b0;
            tx_half <= 1'b0;
        end else begin
            if (byte_step && xfer_last) active <= 1'b0;
            if (rx_fire) begin
                have_lo <= !have_lo && !byte_last;
                lo_byte <= card_rx_data;
            end
            if (tx_fire) tx_half <= !tx_half && !byte_last;
        end
    end

    // Configuration and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '{rx_en: 1'b0, af_lvl: '1, tx_en: 1'b0, ae_lvl: '0};
            int_mask <= '0;
        end else if (host_wr) begin
            if (host_addr == ADDR_BUFCFG) begin
                cfg.rx_en  <= host_wdata[CFG_RXEN_BIT];
                cfg.af_lvl <= host_wdata[CFG_AF_LSB +: LVL_W];
                cfg.tx_en  <= host_wdata[CFG_TXEN_BIT];
                cfg.ae_lvl <= host_wdata[CFG_AE_LSB +: LVL_W];
            end
            if (host_addr == ADDR_MASK) int_mask <= host_wdata[MASK_W-1:0];
        end
    end

    // Status bits: done is set on completion and cleared by writing one; level bits track.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            st_af   <= 1'b0;
            st_ae   <= 1'b0;
        end else begin
            st_af <= af_flag;
            st_ae <= ae_flag;
            if (byte_step && xfer_last)
                st_done <= 1'b1;
            else if (host_wr && (host_addr == ADDR_STATUS) && host_wdata[ST_DONE_BIT])
                st_done <= 1'b0;
        end
    end

    // Status word assembly and masked interrupt.
    always_comb begin
        status_vec              = '0;
        status_vec[ST_DONE_BIT] = st_done;
        status_vec[ST_AF_BIT]   = st_af;
        status_vec[ST_AE_BIT]   = st_ae;
        irq = |(status_vec[MASK_W-1:0] & int_mask);
    end

    // Host read data mux.
    always_comb begin
        case (host_addr)
            ADDR_DATA:   host_rdata = head;
            ADDR_BLKLEN: host_rdata = 16'(bytes_left);
            ADDR_BLKCNT: host_rdata = 16'(blocks_left);
            ADDR_BUFCFG: host_rdata = {cfg.rx_en, 2'b00, cfg.af_lvl, cfg.tx_en, 2'b00, cfg.ae_lvl};
            ADDR_STATUS: host_rdata = status_vec;
            ADDR_MASK:   host_rdata = 16'(int_mask);
            default:     host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/xfer_block_fifo_chk.sv
// Property checker for the block transfer FIFO, bound into every instance.
module xfer_block_fifo_chk #(
    parameter int CNT_W = 6,
    parameter int DEPTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] fill_cnt,
    input logic [4:0]       af_lvl,
    input logic             rx_en,
    input logic             active,
    input logic             st_done,
    input logic             card_rx_ready,
    input logic             card_tx_valid,
    input logic             dma_rx_req,
    input logic             dma_tx_req
);
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    assert_tx_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid |-> fill_cnt != '0);

    assert_done_needs_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> $past(active));

    assert_rx_ready_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> fill_cnt <= CNT_W'(af_lvl));

    assert_rx_req_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> rx_en);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && fill_cnt == '0) |-> (!dma_rx_req && !dma_tx_req));

    assert_one_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rx_ready && card_tx_valid));

endmodule

bind xfer_block_fifo xfer_block_fifo_chk #(
    .CNT_W (CNT_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fill_cnt      (fill_cnt),
    .af_lvl        (cfg.af_lvl),
    .rx_en         (cfg.rx_en),
    .active        (active),
    .st_done       (st_done),
    .card_rx_ready (card_rx_ready),
    .card_tx_valid (card_tx_valid),
    .dma_rx_req    (dma_rx_req),
    .dma_tx_req    (dma_tx_req)
);

// File: tb/tb_xfer_block_fifo.sv
`timescale 1ns/1ps
module tb_xfer_block_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        xfer_start = 1'b0;
    logic        xfer_dir = 1'b0;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;
    logic        dma_rx_req;
    logic        dma_tx_req;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0]  bytes [64];
    logic [15:0] ents [32];

    localparam logic [2:0] A_DATA = 3'd0, A_LEN = 3'd1, A_CNT = 3'd2,
                           A_CFG = 3'd3, A_ST = 3'd4, A_MASK = 3'd5;

    always #4 clk = ~clk;

    xfer_block_fifo dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_start(xfer_start), .xfer_dir(xfer_dir),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
        .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
        .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
        .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req), .irq(irq)
    );

    function automatic logic [15:0] pack_pair(input logic [7:0] lo, input logic [7:0] hi,
                                              input bit single);
        return single ? {8'h00, lo} : {hi, lo};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic dir);
        @(negedge clk);
        xfer_start = 1'b1; xfer_dir = dir;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic card_send(input logic [7:0] b);
        @(negedge clk);
        card_rx_valid = 1'b1; card_rx_data = b;
        #1;
        while (!card_rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic card_take(output logic [7:0] b);
        @(negedge clk);
        card_tx_ready = 1'b1;
        #1;
        while (!card_tx_valid) begin
            @(negedge clk);
            #1;
        end
        b = card_tx_data;
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(A_CFG, v);  chk("R9 reset buffer config", v, 16'h1F00);
        rd(A_ST, v);   chk("R10 reset status", v, 16'h0000);
        chk("R10 reset irq", irq, 0);
        chk("R8 reset dma", {dma_rx_req, dma_tx_req}, 0);
        chk("R5 reset rx ready", card_rx_ready, 0);

        // R1: full FIFO drops the 33rd write, empty read is stale and does not pop
        for (int i = 0; i < 33; i++) wr(A_DATA, 16'h0100 + 16'(i));
        for (int i = 0; i < 32; i++) begin
            rd(A_DATA, v);
            chk("R1 fifo order / full drop", v, 16'h0100 + 16'(i));
        end
        rd(A_DATA, v); chk("R1 empty read returns head", v, 16'h0100);
        rd(A_DATA, v); chk("R1 empty read does not pop", v, 16'h0100);

        // R4: counter readback after programming
        wr(A_LEN, 16'd5); wr(A_CNT, 16'd2);
        rd(A_LEN, v); chk("R4 block length plus one", v, 16'd6);
        rd(A_CNT, v); chk("R4 block count plus one", v, 16'd3);

        // R2/R4: directed read, length 3, two blocks
        wr(A_LEN, 16'd2); wr(A_CNT, 16'd0 + 16'd1); wr(A_MASK, 16'h0008);
        start(1'b1);
        for (int i = 0; i < 6; i++) begin
            bytes[i] = 8'($urandom);
            card_send(bytes[i]);
        end
        @(negedge clk); card_rx_valid = 1'b0;
        #1 chk("R4 transfer ended, rx ready low", card_rx_ready, 0);
        rd(A_ST, v); chk("R4 done bit", v[3], 1);
        chk("R10 irq on masked done", irq, 1);
        rd(A_DATA, v); chk("R2 pair entry", v, pack_pair(bytes[0], bytes[1], 0));
        rd(A_DATA, v); chk("R2 single-byte entry", v, pack_pair(bytes[2], 8'h00, 1));
        rd(A_DATA, v); chk("R2 pair entry block 2", v, pack_pair(bytes[3], bytes[4], 0));
        rd(A_DATA, v); chk("R2 single-byte entry block 2", v, pack_pair(bytes[5], 8'h00, 1));
        rd(A_DATA, v); chk("R1 stale head after drain", v, 16'h0104);
        rd(A_DATA, v); chk("R1 stale head repeated", v, 16'h0104);
        rd(A_LEN, v); chk("R4 byte counter reloaded", v, 16'd3);
        wr(A_ST, 16'h0008);
        rd(A_ST, v); chk("R10 write-one clears done", v, 16'h0000);
        chk("R10 irq clears", irq, 0);

        // R5/R6: almost-full level 1 in the read direction
        wr(A_CFG, 16'h0100); wr(A_LEN, 16'd7); wr(A_CNT, 16'd0);
        start(1'b1);
        for (int i = 0; i < 4; i++) card_send(8'(i + 16));
        @(negedge clk); card_rx_valid = 1'b0;
        #1 chk("R5 rx ready drops above level", card_rx_ready, 0);
        idle(2);
        rd(A_ST, v); chk("R6 status bit 10 without DMA", v[10], 1);
        chk("R6 no rx request without DMA", dma_rx_req, 0);
        wr(A_MASK, 16'h0400);
        chk("R10 irq from masked bit 10", irq, 1);
        wr(A_CFG, 16'h8100);
        chk("R6 rx request with DMA", dma_rx_req, 1);
        idle(2);
        rd(A_ST, v); chk("R6 bit 10 clears with DMA", v[10], 0);
        rd(A_DATA, v); chk("R2 threshold entry", v, 16'h1110);
        #1 chk("R5 rx ready back at level", card_rx_ready, 1);
        chk("R6 rx request drops at level", dma_rx_req, 0);

        // R11: start flushes leftover entries
        wr(A_CFG, 16'h1F00); wr(A_MASK, 16'h0000);
        start(1'b0);
        #1 chk("R11 start flushes FIFO", card_tx_valid, 0);

        // R7/R3: write direction, almost-empty level 4, block ends mid-entry
        wr(A_CFG, 16'h1F04); wr(A_LEN, 16'd2); wr(A_CNT, 16'd0);
        start(1'b0);
        idle(2);
        rd(A_ST, v); chk("R7 status bit 11 below level", v[11], 1);
        wr(A_DATA, 16'hA1A0); wr(A_DATA, 16'hB1B0);
        wr(A_CFG, 16'h1F84);
        chk("R7 tx request with DMA", dma_tx_req, 1);
        idle(2);
        rd(A_ST, v); chk("R7 bit 11 clears with DMA", v[11], 0);
        card_take(b); chk("R3 low byte first", b, 8'hA0);
        card_take(b); chk("R3 high byte second", b, 8'hA1);
        card_take(b); chk("R3 last byte is low of entry", b, 8'hB0);
        @(negedge clk); card_tx_ready = 1'b0;
        #1 chk("R3 half entry popped, idle requests low", dma_tx_req, 0);
        chk("R8 no tx valid when idle", card_tx_valid, 0);
        rd(A_ST, v); chk("R4 write done bit", v[3], 1);
        idle(2);
        rd(A_ST, v); chk("R8 level bits clear when idle empty", v[11:10], 0);

        // Random read transfers
        for (int it = 0; it < 12; it++) begin
            int len, nb, e;
            len = 1 + int'($urandom % 8);
            nb  = 1 + int'($urandom % 3);
            wr(A_CFG, 16'h1F00); wr(A_LEN, 16'(len - 1)); wr(A_CNT, 16'(nb - 1));
            wr(A_ST, 16'hFFFF);
            start(1'b1);
            for (int k = 0; k < len * nb; k++) begin
                bytes[k] = 8'($urandom);
                card_send(bytes[k]);
                if ($urandom % 3 == 0) begin
                    @(negedge clk); card_rx_valid = 1'b0;
                end
            end
            @(negedge clk); card_rx_valid = 1'b0;
            rd(A_ST, v); chk("R4 random read done", v[3], 1);
            e = 0;
            for (int bk = 0; bk < nb; bk++) begin
                for (int i = 0; i < len; i += 2) begin
                    rd(A_DATA, v);
                    chk("R2 random read entry", v,
                        pack_pair(bytes[bk*len+i], (i + 1 < len) ? bytes[bk*len+i+1] : 8'h00,
                                  i + 1 >= len));
                    e++;
                end
            end
        end

        // Random write transfers
        for (int it = 0; it < 12; it++) begin
            int len, nb, ne, e;
            len = 1 + int'($urandom % 8);
            nb  = 1 + int'($urandom % 3);
            ne  = nb * ((len + 1) / 2);
            wr(A_CFG, 16'h1F00); wr(A_LEN, 16'(len - 1)); wr(A_CNT, 16'(nb - 1));
            wr(A_ST, 16'hFFFF);
            start(1'b0);
            for (int k = 0; k < ne; k++) begin
                ents[k] = 16'($urandom);
                wr(A_DATA, ents[k]);
            end
            e = 0;
            for (int bk = 0; bk < nb; bk++) begin
                for (int i = 0; i < len; i++) begin
                    card_take(b);
                    chk("R3 random write byte", b, (i % 2 == 0) ? ents[e][7:0] : ents[e][15:8]);
                    if (i % 2 == 1 || i == len - 1) e++;
                end
            end
            @(negedge clk); card_tx_ready = 1'b0;
            rd(A_ST, v); chk("R4 random write done", v[3], 1);
            chk("R8 random write drained", card_tx_valid, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule